// File: doc/BRIEF.md
# Shadowed Multi-Edge PWM Timing Generator

This block drives a set of pulse-width outputs for a switched-mode power stage: four main bridge outputs, two synchronous rectifier outputs and one auxiliary output with the default parameters. All of them share one switching period, counted in timing steps by a free-running counter. Each output has its own programmable rising and falling edge inside that period. A modulation demand from the control loop moves only those edges that are marked as modulated. The demand is first clamped between a high and a low limit, both taken as fractions of the period.

Configuration arrives through a simple write port and lands in a shadow copy. The running timing changes only after a commit request, and then only at the end of a switching period. All fields change together, so a live converter never runs with half-written timing. Pulse skipping for light load, split modulation for a full bridge, per-output disables and a two-speed shutdown on a fault input complete the block.

Top module: `pwm_edge_timing`

## Requirements
- R1: After reset every output is low, `clamp_flag` is 0 and `commit_pending` is 0. The active period is 0, so every clock ends a period.
- R2: A write changes only the shadow copy. Writing the control register (address 2N+4) with bit 0 set raises `commit_pending`. At the next end of period the whole shadow copy moves to the active set in one step and `commit_pending` returns to 0. A commit request written in the same cycle as an end of period waits for the following one.
- R3: The counter runs from 0 up to the active period value and then wraps to 0. Output i is high while the counter value c satisfies rise_i <= c < fall_i. The write addresses are: 0 for the period; 1 for the limit register; 2+2i for the rise edge of output i and 3+2i for its fall edge; 2N+2 for the rise-modulation enables (bit i = output i); 2N+3 for the fall-modulation enables.
- R4: An edge whose enable bit is set is delayed by the modulation shift. An edge whose enable bit is clear stays at its programmed value.
- R5: Let T = period+1. The limit register holds the high field in bits [6:4] and the low field in bits [1:0]. The high limit is floor((hi+1)*T/8) and the low limit is floor(lo*T/16). The demand is raised to the low limit, and the result is then capped at the high limit.
- R6: `clamp_flag` is 1 for a whole period when the demand sampled for that period was above the high limit or below the low limit.
- R7: When limit bit 2 (skip enable) is set and the sampled demand is below the low limit, every output with at least one modulated edge stays low for that period.
- R8: When limit bit 7 (full-bridge) is set, the modulation shift is half of the clamped value, rounded down.
- R9: The control register carries one disable bit per output: bits [N:1] for outputs 0..N-1. A disabled output stays low.
- R10: A high `flag_in` forces the auxiliary output (the last one) low from the next clock. When limit bit 3 is set, the other outputs stop only from the next period boundary at which `flag_in` is sampled high. When bit 3 is clear, they stop from the next clock as well.
- R11: The demand and the fault input for the period-boundary decisions are sampled only at the end of a period. A change of `mod_in` within a period has no effect until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timing step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | EDGE_W | Register write data |
| mod_in | input | EDGE_W | Modulation demand in timing steps |
| flag_in | input | 1 | Fault shutdown request, level sensitive |
| pwm_out | output | NUM_OUT | Pulse outputs, index NUM_OUT-1 is auxiliary |
| clamp_flag | output | 1 | Demand hit a limit in the current period |
| commit_pending | output | 1 | A commit request waits for the period end |

## Verification
A wrong active register or a missed commit shows as an edge at the wrong counter value within one period of the expected boundary. A stale or mis-clamped shift moves only the modulated edges, and it does so for a whole period. A wrong shutdown or skip state blanks outputs one cycle or one period too early or too late. The reference model predicts every output bit and both flags on every cycle, so such a fault surfaces at the first differing clock rather than at a later directed check.

// File: rtl/pwm_tmg_pkg.sv
package pwm_tmg_pkg;
   // limit register field positions (decoded by the modulation calculator)
   localparam int unsigned LIM_LO_LSB   = 0;
   localparam int unsigned LIM_SKIP_BIT = 2;
   localparam int unsigned LIM_AUXF_BIT = 3;
   localparam int unsigned LIM_HI_LSB   = 4;
   localparam int unsigned LIM_FB_BIT   = 7;

   // write address map
   localparam int unsigned ADDR_PERIOD = 0;
   localparam int unsigned ADDR_LIMIT  = 1;
   localparam int unsigned ADDR_EDGE0  = 2;

   function automatic int unsigned addr_rise_en(int unsigned n_out);
      return ADDR_EDGE0 + 2 * n_out;
   endfunction

   function automatic int unsigned addr_fall_en(int unsigned n_out);
      return ADDR_EDGE0 + 2 * n_out + 1;
   endfunction

   function automatic int unsigned addr_ctrl(int unsigned n_out);
      return ADDR_EDGE0 + 2 * n_out + 2;
   endfunction
endpackage

// File: rtl/pwm_tmg_shadow.sv
module pwm_tmg_shadow
   import pwm_tmg_pkg::*;
#(
   parameter int unsigned NUM_OUT = 7,
   parameter int unsigned EDGE_W  = 8,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [EDGE_W-1:0]                wr_data,
   input  logic                             period_end,
   output logic [EDGE_W-1:0]                act_period,
   output logic [EDGE_W-1:0]                act_limit,
   output logic [EDGE_W-1:0]                nxt_period,
   output logic [EDGE_W-1:0]                nxt_limit,
   output logic [NUM_OUT-1:0][EDGE_W-1:0]   act_rise,
   output logic [NUM_OUT-1:0][EDGE_W-1:0]   act_fall,
   output logic [NUM_OUT-1:0]               act_ren,
   output logic [NUM_OUT-1:0]               act_fen,
   output logic [NUM_OUT-1:0]               act_dis,
   output logic                             pending
);
   localparam int unsigned A_REN  = addr_rise_en(NUM_OUT);
   localparam int unsigned A_FEN  = addr_fall_en(NUM_OUT);
   localparam int unsigned A_CTRL = addr_ctrl(NUM_OUT);

   logic                commit;
   logic                hit_per, hit_lim, hit_ren, hit_fen, hit_ctrl;
   logic [EDGE_W-1:0]   sh_period, sh_limit;
   logic [NUM_OUT-1:0]  sh_ren, sh_fen, sh_dis;

   assign commit   = period_end & pending;
   assign hit_per  = wr_en && (wr_addr == ADDR_W'(ADDR_PERIOD));
   assign hit_lim  = wr_en && (wr_addr == ADDR_W'(ADDR_LIMIT));
   assign hit_ren  = wr_en && (wr_addr == ADDR_W'(A_REN));
   assign hit_fen  = wr_en && (wr_addr == ADDR_W'(A_FEN));
   assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));

   // shadow copy of the shared fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_period <= '0;
         sh_limit  <= '0;
         sh_ren    <= '0;
         sh_fen    <= '0;
         sh_dis    <= '0;
      end else begin
         if (hit_per)  sh_period <= wr_data;
         if (hit_lim)  sh_limit  <= wr_data;
         if (hit_ren)  sh_ren    <= wr_data[NUM_OUT-1:0];
         if (hit_fen)  sh_fen    <= wr_data[NUM_OUT-1:0];
         if (hit_ctrl) sh_dis    <= wr_data[NUM_OUT:1];
      end
   end

   // active copy of the shared fields, loaded only at a committing period end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_period <= '0;
         act_limit  <= '0;
         act_ren    <= '0;
         act_fen    <= '0;
         act_dis    <= '0;
      end else if (commit) begin
         act_period <= sh_period;
         act_limit  <= sh_limit;
         act_ren    <= sh_ren;
         act_fen    <= sh_fen;
         act_dis    <= sh_dis;
      end
   end

   // a new request wins over the clear of the one being committed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pending <= 1'b0;
      else if (hit_ctrl && wr_data[0]) pending <= 1'b1;
      else if (commit)                 pending <= 1'b0;
   end

   assign nxt_period = commit ? sh_period : act_period;
   assign nxt_limit  = commit ? sh_limit  : act_limit;

   // per-output edge registers
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_edge
      logic [EDGE_W-1:0] sh_r, sh_f, ac_r, ac_f;
      logic              hit_r, hit_f;

      assign hit_r = wr_en && (wr_addr == ADDR_W'(ADDR_EDGE0 + 2 * i));
      assign hit_f = wr_en && (wr_addr == ADDR_W'(ADDR_EDGE0 + 2 * i + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_r <= '0;
            sh_f <= '0;
         end else begin
            if (hit_r) sh_r <= wr_data;
            if (hit_f) sh_f <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ac_r <= '0;
            ac_f <= '0;
         end else if (commit) begin
            ac_r <= sh_r;
            ac_f <= sh_f;
         end
      end

      assign act_rise[i] = ac_r;
      assign act_fall[i] = ac_f;
   end
endmodule

// File: rtl/pwm_tmg_modcalc.sv
module pwm_tmg_modcalc
   import pwm_tmg_pkg::*;
#(
   parameter int unsigned EDGE_W     = 8,
   parameter bit          FB_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [EDGE_W-1:0] cfg_period,
   input  logic [EDGE_W-1:0] cfg_limit,
   input  logic [EDGE_W-1:0] mod_in,
   output logic [EDGE_W:0]   mod_shift,
   output logic              skip_q,
   output logic              clamp_q
);
   localparam int unsigned TW = EDGE_W + 1;
   localparam int unsigned PW = TW + 4;

   logic [TW-1:0] ticks, hi_lim, lo_lim, demand, floor_v, applied, shift_n;
   logic [PW-1:0] hi_prod, lo_prod;
   logic [2:0]    hi_f;
   logic [1:0]    lo_f;
   logic          below, above;

   assign hi_f    = cfg_limit[LIM_HI_LSB +: 3];
   assign lo_f    = cfg_limit[LIM_LO_LSB +: 2];
   assign ticks   = {1'b0, cfg_period} + TW'(1);
   assign hi_prod = (PW'(hi_f) + PW'(1)) * PW'(ticks);
   assign lo_prod = PW'(lo_f) * PW'(ticks);
   assign hi_lim  = TW'(hi_prod >> 3);
   assign lo_lim  = TW'(lo_prod >> 4);
   assign demand  = {1'b0, mod_in};
   assign below   = demand < lo_lim;
   assign above   = demand > hi_lim;
   assign floor_v = below ? lo_lim : demand;
   assign applied = (floor_v > hi_lim) ? hi_lim : floor_v;

   if (FB_SUPPORT) begin : g_fb
      assign shift_n = cfg_limit[LIM_FB_BIT] ? (applied >> 1) : applied;
   end else begin : g_nofb
      assign shift_n = applied;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_shift <= '0;
         skip_q    <= 1'b0;
         clamp_q   <= 1'b0;
      end else if (load) begin
         mod_shift <= shift_n;
         skip_q    <= cfg_limit[LIM_SKIP_BIT] & below;
         clamp_q   <= below | above;
      end
   end
endmodule

// File: rtl/pwm_tmg_edge_cell.sv
module pwm_tmg_edge_cell #(
   parameter int unsigned EDGE_W = 8
) (
   input  logic [EDGE_W-1:0] cnt,
   input  logic [EDGE_W-1:0] rise,
   input  logic [EDGE_W-1:0] fall,
   input  logic              ren,
   input  logic              fen,
   input  logic [EDGE_W:0]   shift,
   input  logic              dis,
   input  logic              skip,
   input  logic              stop,
   output logic              pwm
);
   localparam int unsigned SW = EDGE_W + 1;

   logic [SW-1:0] r_eff, f_eff, c_ext;
   logic          window, blank;

   assign c_ext  = {1'b0, cnt};
   assign r_eff  = {1'b0, rise} + (ren ? shift : '0);
   assign f_eff  = {1'b0, fall} + (fen ? shift : '0);
   assign window = (c_ext >= r_eff) && (c_ext < f_eff);
   assign blank  = skip & (ren | fen);
   assign pwm    = window & ~dis & ~blank & ~stop;
endmodule

// File: rtl/pwm_edge_timing.sv
module pwm_edge_timing
   import pwm_tmg_pkg::*;
#(
   parameter int unsigned NUM_OUT    = 7,
   parameter int unsigned EDGE_W     = 8,
   parameter int unsigned ADDR_W     = 5,
   parameter bit          HAS_AUX    = 1'b1,
   parameter bit          FB_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [EDGE_W-1:0]  wr_data,
   input  logic [EDGE_W-1:0]  mod_in,
   input  logic               flag_in,
   output logic [NUM_OUT-1:0] pwm_out,
   output logic               clamp_flag,
   output logic               commit_pending
);
   localparam int unsigned LAST_ADDR = addr_ctrl(NUM_OUT);
   localparam int unsigned AUX_IDX   = NUM_OUT - 1;

   if (NUM_OUT < 2 || NUM_OUT + 1 > EDGE_W) begin : g_bad_count
      $error("pwm_edge_timing: NUM_OUT must be 2..EDGE_W-1");
   end
   if (EDGE_W < 4) begin : g_bad_width
      $error("pwm_edge_timing: EDGE_W must be at least 4");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("pwm_edge_timing: ADDR_W too narrow for the register map");
   end

   logic [EDGE_W-1:0]              cnt_q;
   logic                           period_end;
   logic [EDGE_W-1:0]              act_period, act_limit, nxt_period, nxt_limit;
   logic [NUM_OUT-1:0][EDGE_W-1:0] act_rise, act_fall;
   logic [NUM_OUT-1:0]             act_ren, act_fen, act_dis;
   logic [EDGE_W:0]                mod_shift;
   logic                           skip_q;
   logic                           halt_now, halt_cyc;
   logic                           aux_fast;

   assign period_end = (cnt_q == act_period);
   assign aux_fast   = act_limit[LIM_AUXF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (period_end) cnt_q <= '0;
      else                 cnt_q <= cnt_q + EDGE_W'(1);
   end

   // fault shutdown: per-cycle and per-period samples of the fault input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_now <= 1'b0;
         halt_cyc <= 1'b0;
      end else begin
         halt_now <= flag_in;
         if (period_end) halt_cyc <= flag_in;
      end
   end

   pwm_tmg_shadow #(
      .NUM_OUT (NUM_OUT),
      .EDGE_W  (EDGE_W),
      .ADDR_W  (ADDR_W)
   ) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .period_end (period_end),
      .act_period (act_period),
      .act_limit  (act_limit),
      .nxt_period (nxt_period),
      .nxt_limit  (nxt_limit),
      .act_rise   (act_rise),
      .act_fall   (act_fall),
      .act_ren    (act_ren),
      .act_fen    (act_fen),
      .act_dis    (act_dis),
      .pending    (commit_pending)
   );

   pwm_tmg_modcalc #(
      .EDGE_W     (EDGE_W),
      .FB_SUPPORT (FB_SUPPORT)
   ) u_modcalc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (period_end),
      .cfg_period (nxt_period),
      .cfg_limit  (nxt_limit),
      .mod_in     (mod_in),
      .mod_shift  (mod_shift),
      .skip_q     (skip_q),
      .clamp_q    (clamp_flag)
   );

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      logic stop_i;
      if (HAS_AUX && i == AUX_IDX) begin : g_aux
         assign stop_i = halt_now;
      end else begin : g_main
         assign stop_i = aux_fast ? halt_cyc : halt_now;
      end

      pwm_tmg_edge_cell #(
         .EDGE_W (EDGE_W)
      ) u_cell (
         .cnt   (cnt_q),
         .rise  (act_rise[i]),
         .fall  (act_fall[i]),
         .ren   (act_ren[i]),
         .fen   (act_fen[i]),
         .shift (mod_shift),
         .dis   (act_dis[i]),
         .skip  (skip_q),
         .stop  (stop_i),
         .pwm   (pwm_out[i])
      );
   end
endmodule

// File: rtl/pwm_tmg_chk.sv
module pwm_tmg_chk #(
   parameter int unsigned NUM_OUT = 7,
   parameter int unsigned EDGE_W  = 8,
   parameter bit          HAS_AUX = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flag_in,
   input logic               period_end,
   input logic               pending,
   input logic [EDGE_W-1:0]  cnt,
   input logic [EDGE_W-1:0]  act_period,
   input logic [NUM_OUT-1:0] act_dis,
   input logic [NUM_OUT-1:0] act_ren,
   input logic [NUM_OUT-1:0] act_fen,
   input logic [NUM_OUT-1:0] pwm_out,
   input logic               skip_q,
   input logic [EDGE_W:0]    mod_shift
);
   assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act_period);

   assert_pend_clears_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(period_end));

   assert_disabled_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_dis & pwm_out) == '0);

   assert_skip_blanks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> ((pwm_out & (act_ren | act_fen)) == '0));

   assert_shift_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(period_end)) |-> $stable(mod_shift));

   if (HAS_AUX) begin : g_aux_chk
      assert_aux_stops_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(flag_in)) |-> !pwm_out[NUM_OUT-1]);
   end
endmodule

bind pwm_edge_timing pwm_tmg_chk #(
   .NUM_OUT (NUM_OUT),
   .EDGE_W  (EDGE_W),
   .HAS_AUX (HAS_AUX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_in    (flag_in),
   .period_end (period_end),
   .pending    (commit_pending),
   .cnt        (cnt_q),
   .act_period (act_period),
   .act_dis    (act_dis),
   .act_ren    (act_ren),
   .act_fen    (act_fen),
   .pwm_out    (pwm_out),
   .skip_q     (skip_q),
   .mod_shift  (mod_shift)
);

// File: tb/pwm_edge_timing_tb.sv
module pwm_edge_timing_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 7;
   localparam int A_REN  = 2 + 2 * N;
   localparam int A_FEN  = 3 + 2 * N;
   localparam int A_CTRL = 4 + 2 * N;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [4:0]   wr_addr = '0;
   logic [7:0]   wr_data = '0;
   logic [7:0]   mod_in = '0;
   logic         flag_in = 1'b0;
   logic [N-1:0] pwm_out;
   logic         clamp_flag;
   logic         commit_pending;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   string tag = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwm_edge_timing u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .mod_in         (mod_in),
      .flag_in        (flag_in),
      .pwm_out        (pwm_out),
      .clamp_flag     (clamp_flag),
      .commit_pending (commit_pending)
   );

   // behavioural reference model
   int m_cnt, a_per, s_per, a_lim, s_lim, a_ren, a_fen, a_dis, s_ren, s_fen, s_dis;
   int a_r[N], a_f[N], s_r[N], s_f[N];
   int m_shift;
   bit pend, m_skip, m_clamp, h_now, h_cyc;

   task automatic model_step();
      bit bnd, com;
      int per, lim, ticks, hl, ll, m, ap;
      if (!rst_n) begin
         m_cnt = 0; a_per = 0; s_per = 0; a_lim = 0; s_lim = 0;
         a_ren = 0; a_fen = 0; a_dis = 0; s_ren = 0; s_fen = 0; s_dis = 0;
         for (int i = 0; i < N; i++) begin
            a_r[i] = 0; a_f[i] = 0; s_r[i] = 0; s_f[i] = 0;
         end
         m_shift = 0; pend = 0; m_skip = 0; m_clamp = 0; h_now = 0; h_cyc = 0;
         return;
      end
      bnd = (m_cnt == a_per);
      com = bnd && pend;
      if (bnd) begin
         per = com ? s_per : a_per;
         lim = com ? s_lim : a_lim;
         ticks = per + 1;
         hl = ((((lim >> 4) & 7) + 1) * ticks) / 8;
         ll = ((lim & 3) * ticks) / 16;
         m = int'(mod_in);
         m_clamp = (m > hl) || (m < ll);
         m_skip = (((lim >> 2) & 1) != 0) && (m < ll);
         ap = (m < ll) ? ll : m;
         ap = (ap > hl) ? hl : ap;
         m_shift = (((lim >> 7) & 1) != 0) ? ap / 2 : ap;
         h_cyc = flag_in;
      end
      if (com) begin
         a_per = s_per; a_lim = s_lim; a_ren = s_ren; a_fen = s_fen; a_dis = s_dis;
         for (int i = 0; i < N; i++) begin
            a_r[i] = s_r[i]; a_f[i] = s_f[i];
         end
         pend = 0;
      end
      if (wr_en) begin
         int ad = int'(wr_addr);
         int d  = int'(wr_data);
         if (ad == 0) s_per = d;
         else if (ad == 1) s_lim = d;
         else if (ad == A_REN) s_ren = d & 'h7f;
         else if (ad == A_FEN) s_fen = d & 'h7f;
         else if (ad == A_CTRL) begin
            s_dis = (d >> 1) & 'h7f;
            if ((d & 1) != 0) pend = 1;
         end else if (ad >= 2 && ad < 2 + 2 * N) begin
            if ((ad % 2) == 0) s_r[(ad - 2) / 2] = d;
            else s_f[(ad - 2) / 2] = d;
         end
      end
      h_now = flag_in;
      m_cnt = bnd ? 0 : m_cnt + 1;
   endtask

   function automatic logic [N-1:0] exp_out();
      logic [N-1:0] v;
      v = '0;
      for (int i = 0; i < N; i++) begin
         int r = a_r[i] + ((((a_ren >> i) & 1) != 0) ? m_shift : 0);
         int f = a_f[i] + ((((a_fen >> i) & 1) != 0) ? m_shift : 0);
         bit stop = (i == N - 1) ? h_now : ((((a_lim >> 3) & 1) != 0) ? h_cyc : h_now);
         bit blank = m_skip && ((((a_ren | a_fen) >> i) & 1) != 0);
         bit dis = (((a_dis >> i) & 1) != 0);
         v[i] = !dis && !blank && !stop && (m_cnt >= r) && (m_cnt < f);
      end
      return v;
   endfunction

   always @(posedge clk) model_step();

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [N-1:0] e;
         e = exp_out();
         checks++;
         if (pwm_out !== e || clamp_flag !== m_clamp || commit_pending !== pend) begin
            fails++;
            $display("FAIL %s cycle compare: pwm=%b clamp=%b pend=%b expected pwm=%b clamp=%b pend=%b",
                     tag, pwm_out, clamp_flag, commit_pending, e, m_clamp, pend);
         end
      end
   end

   task automatic hand_check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      hand_check(pwm_out == '0, "R1 outputs", int'(pwm_out), 0);
      hand_check(!clamp_flag, "R1 clamp_flag", int'(clamp_flag), 0);
      hand_check(!commit_pending, "R1 commit_pending", int'(commit_pending), 0);

      // program the shadow set without a commit
      tag = "R2";
      wr(0, 19);
      wr(1, 'h32);
      wr(2, 2);  wr(3, 10);
      wr(4, 5);  wr(5, 15);
      wr(6, 0);  wr(7, 8);
      wr(8, 10); wr(9, 19);
      wr(10, 1); wr(11, 9);
      wr(12, 11); wr(13, 19);
      wr(14, 3); wr(15, 6);
      wr(A_REN, 'h02);
      wr(A_FEN, 'h0B);
      run(4);
      hand_check(pwm_out == '0, "R2 shadow held back", int'(pwm_out), 0);
      wr(A_CTRL, 'h01);
      hand_check(commit_pending, "R2 pending after request", int'(commit_pending), 1);
      run(2);
      hand_check(!commit_pending, "R2 pending self-clear", int'(commit_pending), 0);

      tag = "R3 R4";
      mod_in = 8'd4;
      run(60);
      tag = "R5 R6";
      mod_in = 8'd30;
      run(40);
      hand_check(clamp_flag, "R6 clamp high", int'(clamp_flag), 1);
      mod_in = 8'd0;
      run(40);
      hand_check(clamp_flag, "R5 R6 clamp low", int'(clamp_flag), 1);

      tag = "R7";
      wr(1, 'h36); wr(A_CTRL, 'h01);
      mod_in = 8'd1;
      run(45);
      mod_in = 8'd5;
      run(25);

      tag = "R8";
      wr(1, 'hB2); wr(A_CTRL, 'h01);
      mod_in = 8'd8;
      run(45);

      tag = "R9";
      wr(A_CTRL, 'h05);
      run(45);

      tag = "R2 mid-period";
      run(7);
      wr(7, 12); wr(A_CTRL, 'h05);
      run(45);

      tag = "R10";
      wr(1, 'h3A); wr(A_CTRL, 'h01);
      run(30);
      run(4);
      flag_in = 1'b1;
      @(negedge clk);
      hand_check(!pwm_out[N-1], "R10 aux stops", int'(pwm_out[N-1]), 0);
      run(25);
      flag_in = 1'b0;
      run(30);
      wr(1, 'h32); wr(A_CTRL, 'h01);
      run(25);
      flag_in = 1'b1;
      @(negedge clk);
      hand_check(pwm_out == '0, "R10 all stop", int'(pwm_out), 0);
      run(10);
      flag_in = 1'b0;
      run(30);

      tag = "R11";
      for (int k = 0; k < 12; k++) begin
         mod_in = 8'((k * 7) % 13);
         run(3 + (k % 5));
      end
      run(25);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule